// File: doc/BRIEF.md
# Low Power Idle Entry and Wake Timer Controller

This block sits in the transmit path of an Ethernet MAC and decides when the MAC may present the Low Power Idle (LPI) pattern to the PHY, and when normal frame transmission may start again once LPI ends. Two timers gate these transitions. The link-stable timer counts millisecond ticks while the PHY reports link up. LPI may start only after that count reaches the programmed qualification time. The wake timer counts microsecond ticks after LPI stops. Transmission stays blocked until the programmed wake time has elapsed.

Software programs both times through one 32-bit control word. It enables LPI with a level input and learns of each completed wake through a sticky exit flag. Reading the status clears the flag. The MAC datapath raises a transmit-pending request whenever it has a frame waiting. That request holds the block out of LPI, or pulls it out of LPI.

Top module: `lpi_timer_ctrl`

## Requirements
- R1: After reset the control word reads 0x03E80000 (qualification time 1000 ms, wake time 0). After reset `lpiAssert` is 0, `txAllowed` is 1 and `lpiExitStatus` is 0.
- R2: A control write stores bits 25:16 as the qualification time in milliseconds and bits 15:0 as the wake time in microseconds. Bits 31:26 always read 0, whatever was written to them.
- R3: While link is up, each `msTick` pulse advances the link-stable count. LPI cannot start until the count equals the programmed qualification time. If the qualification time is 0, LPI may start on the first clock with link up.
- R4: The block enters LPI on the clock edge after all of these hold at once: `lpiEnable` is 1, the qualification time has been reached, and `txPending` is 0. While `txPending` is 1, it stays out of LPI.
- R5: While in LPI, a `txPending` of 1 or an `lpiEnable` of 0 ends LPI on the next edge. `lpiAssert` falls and `txAllowed` stays 0.
- R6: After LPI ends, `txAllowed` rises only after the programmed number of `usTick` pulses has been counted. On that same edge, `lpiExitStatus` is set.
- R7: With a wake time of 0, `txAllowed` rises one clock after `lpiAssert` falls, and `lpiExitStatus` is still set.
- R8: If link drops in LPI, `lpiAssert` falls on the next edge and `txAllowed` returns at once. The link-stable count restarts from zero, and no exit status is raised.
- R9: `lpiExitStatus` stays set until a `statusRdEn` pulse clears it. If a wake completes on the same edge as that pulse, the flag stays set.
- R10: The link-stable count stops at the programmed qualification time and does not keep counting. If a larger time is written later, only the difference in further ticks is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 32 | Control word write value |
| ctrlRdData | output | 32 | Control word read value |
| statusRdEn | input | 1 | Status read strobe; clears the exit flag |
| msTick | input | 1 | One-cycle millisecond pulse |
| usTick | input | 1 | One-cycle microsecond pulse |
| linkUp | input | 1 | PHY link status, 1 = up |
| lpiEnable | input | 1 | Software LPI enable |
| txPending | input | 1 | MAC has a frame waiting |
| lpiAssert | output | 1 | Send LPI pattern to PHY |
| txAllowed | output | 1 | Normal transmission permitted |
| lpiExitStatus | output | 1 | Sticky flag: wake time expired |

## Verification
Two functions can fall on the same clock edge: the wake-completion edge that sets the exit flag, and a software status read that clears it. The bench sets a wake time of one microsecond and gives the single `usTick`. On the negative edge after that tick, the wake timer has expired, and the bench raises `statusRdEn` for exactly the following edge. The check passes only if the flag reads 1 and `txAllowed` is 1 after that edge. A later read must then clear the flag, which shows that the read path still works.

// File: rtl/lpi_timer_pkg.sv
package lpi_timer_pkg;

  localparam int CTRL_W = 32;
  localparam int LS_LSB = 16;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_LPI    = 2'd1,
    ST_WAKE   = 2'd2
  } lpiState_t;

  typedef struct packed {
    logic wakeClr;
    logic wakeRun;
    logic exitSet;
  } lpiStrobe_t;

endpackage

// File: rtl/lpi_timer_datapath.sv
module lpi_timer_datapath
  import lpi_timer_pkg::*;
#(
  parameter int LS_W   = 10,
  parameter int TW_W   = 16,
  parameter int LS_RST = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output logic [CTRL_W-1:0] ctrlRdData,
  input  logic              statusRdEn,
  input  logic              msTick,
  input  logic              usTick,
  input  logic              linkUp,
  input  lpiStrobe_t        strobes,
  output logic              linkReady,
  output logic              wakeDone,
  output logic              exitFlag
);

  localparam int LS_MSB = LS_LSB + LS_W - 1;
  localparam logic [LS_W-1:0] LS_INIT = LS_W'(LS_RST);

  logic [LS_W-1:0] lsTime;
  logic [TW_W-1:0] twTime;
  logic [LS_W-1:0] linkCnt;
  logic [TW_W-1:0] wakeCnt;

  // reserved bits of the write word are dropped
  logic unusedRsvd;
  assign unusedRsvd = ^ctrlWrData[CTRL_W-1:LS_MSB+1];

  // control word storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lsTime <= LS_INIT;
      twTime <= '0;
    end else if (ctrlWrEn) begin
      lsTime <= ctrlWrData[LS_MSB:LS_LSB];
      twTime <= ctrlWrData[TW_W-1:0];
    end
  end

  always_comb begin
    ctrlRdData                 = '0;
    ctrlRdData[LS_MSB:LS_LSB]  = lsTime;
    ctrlRdData[TW_W-1:0]       = twTime;
  end

  // link-stable counter: clears on link loss, saturates at lsTime
  always_ff @(posedge clk) begin
    if (!rstN || !linkUp) begin
      linkCnt <= '0;
    end else if (msTick && (linkCnt < lsTime)) begin
      linkCnt <= linkCnt + 1'b1;
    end
  end

  assign linkReady = linkUp && (linkCnt >= lsTime);

  // wake counter: cleared when LPI ends, runs in the wake state
  always_ff @(posedge clk) begin
    if (!rstN || strobes.wakeClr) begin
      wakeCnt <= '0;
    end else if (strobes.wakeRun && usTick && (wakeCnt < twTime)) begin
      wakeCnt <= wakeCnt + 1'b1;
    end
  end

  assign wakeDone = (wakeCnt >= twTime);

  // sticky exit flag: set has priority over read-clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      exitFlag <= 1'b0;
    end else if (strobes.exitSet) begin
      exitFlag <= 1'b1;
    end else if (statusRdEn) begin
      exitFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/lpi_timer_control.sv
module lpi_timer_control
  import lpi_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       linkUp,
  input  logic       lpiEnable,
  input  logic       txPending,
  input  logic       linkReady,
  input  logic       wakeDone,
  output lpiStrobe_t strobes,
  output logic       lpiAssert,
  output logic       txAllowed
);

  lpiState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_ACTIVE: begin
        if (linkReady && lpiEnable && !txPending) stateNext = ST_LPI;
      end
      ST_LPI: begin
        if (!linkUp) begin
          stateNext = ST_ACTIVE;
        end else if (txPending || !lpiEnable) begin
          stateNext       = ST_WAKE;
          strobes.wakeClr = 1'b1;
        end
      end
      ST_WAKE: begin
        strobes.wakeRun = 1'b1;
        if (!linkUp) begin
          stateNext = ST_ACTIVE;
        end else if (wakeDone) begin
          stateNext       = ST_ACTIVE;
          strobes.exitSet = 1'b1;
        end
      end
      default: stateNext = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= stateNext;
  end

  assign lpiAssert = (state == ST_LPI);
  assign txAllowed = (state == ST_ACTIVE);

endmodule

// File: rtl/lpi_timer_ctrl.sv
module lpi_timer_ctrl
  import lpi_timer_pkg::*;
#(
  parameter int LS_W   = 10,
  parameter int TW_W   = 16,
  parameter int LS_RST = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWrEn,
  input  logic [31:0] ctrlWrData,
  output logic [31:0] ctrlRdData,
  input  logic        statusRdEn,
  input  logic        msTick,
  input  logic        usTick,
  input  logic        linkUp,
  input  logic        lpiEnable,
  input  logic        txPending,
  output logic        lpiAssert,
  output logic        txAllowed,
  output logic        lpiExitStatus
);

  lpiStrobe_t strobes;
  logic       linkReady;
  logic       wakeDone;

  lpi_timer_datapath #(
    .LS_W  (LS_W),
    .TW_W  (TW_W),
    .LS_RST(LS_RST)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWrEn  (ctrlWrEn),
    .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData),
    .statusRdEn(statusRdEn),
    .msTick    (msTick),
    .usTick    (usTick),
    .linkUp    (linkUp),
    .strobes   (strobes),
    .linkReady (linkReady),
    .wakeDone  (wakeDone),
    .exitFlag  (lpiExitStatus)
  );

  lpi_timer_control ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .linkUp   (linkUp),
    .lpiEnable(lpiEnable),
    .txPending(txPending),
    .linkReady(linkReady),
    .wakeDone (wakeDone),
    .strobes  (strobes),
    .lpiAssert(lpiAssert),
    .txAllowed(txAllowed)
  );

endmodule

// File: rtl/lpi_timer_ctrl_chk.sv
module lpi_timer_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        ctrlWrEn,
  input logic [31:0] ctrlWrData,
  input logic [31:0] ctrlRdData,
  input logic        statusRdEn,
  input logic        linkUp,
  input logic        lpiEnable,
  input logic        txPending,
  input logic        lpiAssert,
  input logic        txAllowed,
  input logic        lpiExitStatus,
  input logic        linkReady,
  input logic        wakeDone,
  input logic        exitSet
);

  assert_wake_field_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrlWrEn) |-> ctrlRdData[15:0] == $past(ctrlWrData[15:0]));

  assert_entry_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lpiAssert) |-> ($past(linkReady) && $past(lpiEnable) && !$past(txPending)));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(lpiAssert && txAllowed));

  assert_exit_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(lpiAssert) && $past(linkUp)) |-> !txAllowed);

  assert_wake_elapsed_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txAllowed) && !$past(lpiAssert) && $past(linkUp)) |-> ($past(wakeDone) && lpiExitStatus));

  assert_link_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lpiAssert) && !$past(linkUp)) |-> (!lpiAssert && txAllowed));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statusRdEn) && !$past(exitSet)) |-> !lpiExitStatus);

endmodule

bind lpi_timer_ctrl lpi_timer_ctrl_chk chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .ctrlWrEn     (ctrlWrEn),
  .ctrlWrData   (ctrlWrData),
  .ctrlRdData   (ctrlRdData),
  .statusRdEn   (statusRdEn),
  .linkUp       (linkUp),
  .lpiEnable    (lpiEnable),
  .txPending    (txPending),
  .lpiAssert    (lpiAssert),
  .txAllowed    (txAllowed),
  .lpiExitStatus(lpiExitStatus),
  .linkReady    (linkReady),
  .wakeDone     (wakeDone),
  .exitSet      (strobes.exitSet)
);

// File: tb/lpi_timer_ctrl_tb.sv
module lpi_timer_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [31:0] ctrlWrData = '0;
  logic [31:0] ctrlRdData;
  logic        statusRdEn = 1'b0;
  logic        msTick = 1'b0;
  logic        usTick = 1'b0;
  logic        linkUp = 1'b0;
  logic        lpiEnable = 1'b0;
  logic        txPending = 1'b0;
  logic        lpiAssert;
  logic        txAllowed;
  logic        lpiExitStatus;

  int nChk = 0;
  int nErr = 0;

  always #10 clk = ~clk;

  lpi_timer_ctrl dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlWrEn     (ctrlWrEn),
    .ctrlWrData   (ctrlWrData),
    .ctrlRdData   (ctrlRdData),
    .statusRdEn   (statusRdEn),
    .msTick       (msTick),
    .usTick       (usTick),
    .linkUp       (linkUp),
    .lpiEnable    (lpiEnable),
    .txPending    (txPending),
    .lpiAssert    (lpiAssert),
    .txAllowed    (txAllowed),
    .lpiExitStatus(lpiExitStatus)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic writeCtrl(input logic [31:0] v);
    ctrlWrEn = 1'b1; ctrlWrData = v;
    @(posedge clk); @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic msPulse();
    msTick = 1'b1; @(posedge clk); @(negedge clk); msTick = 1'b0;
  endtask

  task automatic usPulse();
    usTick = 1'b1; @(posedge clk); @(negedge clk); usTick = 1'b0;
  endtask

  task automatic readStatus();
    statusRdEn = 1'b1; @(posedge clk); @(negedge clk); statusRdEn = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ctrl word", ctrlRdData, 32'h03E8_0000);
    check("R1 lpiAssert", {31'd0, lpiAssert}, 32'd0);
    check("R1 txAllowed", {31'd0, txAllowed}, 32'd1);
    check("R1 status", {31'd0, lpiExitStatus}, 32'd0);
  endtask

  task automatic t_register();
    writeCtrl(32'hFFFF_FFFF);
    check("R2 reserved read zero", ctrlRdData, 32'h03FF_FFFF);
    writeCtrl(32'h0003_0002);
    check("R2 field readback", ctrlRdData, 32'h0003_0002);
  endtask

  task automatic t_link_gate();
    linkUp = 1'b1; lpiEnable = 1'b1; txPending = 1'b0;
    msPulse(); msPulse();
    step(); step();
    check("R3 no LPI before qual time", {31'd0, lpiAssert}, 32'd0);
    msPulse();
    check("R3 LPI not before next edge", {31'd0, lpiAssert}, 32'd0);
    step();
    check("R4 LPI entered", {31'd0, lpiAssert}, 32'd1);
    check("R4 tx blocked in LPI", {31'd0, txAllowed}, 32'd0);
  endtask

  task automatic t_wake_timer();
    txPending = 1'b1;
    step();
    check("R5 LPI ends on pending", {31'd0, lpiAssert}, 32'd0);
    check("R5 tx still blocked", {31'd0, txAllowed}, 32'd0);
    usPulse();
    step(); step(); step();
    check("R6 blocked after 1 of 2 us", {31'd0, txAllowed}, 32'd0);
    usPulse();
    check("R6 blocked at expiry edge", {31'd0, txAllowed}, 32'd0);
    step();
    check("R6 tx allowed after wake", {31'd0, txAllowed}, 32'd1);
    check("R6 exit status set", {31'd0, lpiExitStatus}, 32'd1);
    step(); step();
    check("R9 status sticky", {31'd0, lpiExitStatus}, 32'd1);
    readStatus();
    check("R9 read clears status", {31'd0, lpiExitStatus}, 32'd0);
  endtask

  task automatic t_pending_blocks();
    step(); step(); step();
    check("R4 pending holds off LPI", {31'd0, lpiAssert}, 32'd0);
    txPending = 1'b0;
    step();
    check("R4 LPI after pending drops", {31'd0, lpiAssert}, 32'd1);
  endtask

  task automatic t_zero_wake();
    writeCtrl(32'h0003_0000);
    lpiEnable = 1'b0;
    step();
    check("R5 LPI ends on disable", {31'd0, lpiAssert}, 32'd0);
    check("R7 tx blocked one cycle", {31'd0, txAllowed}, 32'd0);
    step();
    check("R7 tx allowed next cycle", {31'd0, txAllowed}, 32'd1);
    check("R7 status set", {31'd0, lpiExitStatus}, 32'd1);
    readStatus();
  endtask

  task automatic t_link_drop();
    lpiEnable = 1'b1;
    step();
    check("R4 re-entry", {31'd0, lpiAssert}, 32'd1);
    linkUp = 1'b0;
    step();
    check("R8 LPI left on link drop", {31'd0, lpiAssert}, 32'd0);
    check("R8 tx allowed", {31'd0, txAllowed}, 32'd1);
    check("R8 no status", {31'd0, lpiExitStatus}, 32'd0);
    linkUp = 1'b1;
    msPulse(); msPulse();
    step(); step();
    check("R8 timer restarted", {31'd0, lpiAssert}, 32'd0);
    msPulse();
    step();
    check("R8 LPI after full requal", {31'd0, lpiAssert}, 32'd1);
  endtask

  task automatic t_saturate();
    txPending = 1'b1;
    step(); step();
    readStatus();
    linkUp = 1'b0; step();
    linkUp = 1'b1;
    for (int i = 0; i < 8; i++) msPulse();
    writeCtrl(32'h0005_0000);
    txPending = 1'b0;
    step(); step(); step();
    check("R10 count held at old limit", {31'd0, lpiAssert}, 32'd0);
    msPulse();
    step();
    check("R10 one tick short", {31'd0, lpiAssert}, 32'd0);
    msPulse();
    step();
    check("R10 LPI after difference", {31'd0, lpiAssert}, 32'd1);
    writeCtrl(32'h0000_0000);
    linkUp = 1'b0; step();
    check("R3 left LPI", {31'd0, lpiAssert}, 32'd0);
    linkUp = 1'b1; step();
    check("R3 zero qual time immediate", {31'd0, lpiAssert}, 32'd1);
  endtask

  task automatic t_collision();
    writeCtrl(32'h0000_0001);
    check("R9 status clear before", {31'd0, lpiExitStatus}, 32'd0);
    txPending = 1'b1;
    step();
    usPulse();
    statusRdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    statusRdEn = 1'b0;
    check("R9 set wins over read", {31'd0, lpiExitStatus}, 32'd1);
    check("R6 tx allowed at collision", {31'd0, txAllowed}, 32'd1);
    readStatus();
    check("R9 later read clears", {31'd0, lpiExitStatus}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    t_reset();
    t_register();
    t_link_gate();
    t_wake_timer();
    t_pending_blocks();
    t_zero_wake();
    t_link_drop();
    t_saturate();
    t_collision();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++;
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

endmodule